// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits between a command-stream decoder and a set of execution engines. Each incoming write carries a method number, a subchannel index and a 32-bit value. The router keeps a small table, one entry per subchannel, that records which engine class that subchannel has been bound to. Software fills the table in-band: a write to method zero binds the write's subchannel to the class number carried in the value field.

Writes to methods in the reserved low range are consumed and dropped. Every other write is sent to the engine port chosen by its subchannel's binding. There are three ports: a 2D port, a 3D port and a compute port. Writes that cannot be delivered are dropped and reported through one-hot per-subchannel error pulses. This covers writes on an unbound subchannel, writes on a subchannel bound to a class with no port, and a second bind on a subchannel that is already bound.

Each engine port is a registered valid/ready stage. The router stalls its input only when the port that the current write targets still holds an undelivered write.

Top module: `subch_router`

## Requirements
- R1: A write with method 0 binds its subchannel to the class in the value field and is not forwarded. The subchannel's `bound_mask` bit reads 1 from the cycle after acceptance.
- R2: Writes with method 0x001 to 0x0FF are accepted and dropped. No port receives them and no error bit is set.
- R3: A write with method 0x100 or above is forwarded when its subchannel is bound to a class with a port. Class 0x0000902D goes to the 2D port, 0x0000B197 to the 3D port and 0x0000B1C0 to the compute port. Method and value arrive unchanged, with valid high in the cycle after acceptance.
- R4: A subchannel may be bound to any other class value, including 0xA140 and 0xB0B5. Writes at or above 0x100 on such a subchannel are dropped, and bit s of `err_unsup` pulses for one cycle, where s is the subchannel.
- R5: A bind on an already bound subchannel pulses bit s of `err_rebind` for one cycle and leaves the existing binding in force.
- R6: A write at or above 0x100 on an unbound subchannel is dropped and pulses bit s of `err_unbound` for one cycle.
- R7: Reset (synchronous, active high) clears all bindings, all port valids and all error bits.
- R8: While a port holds valid high with its ready low, its method and value stay stable. A write targeting that port sees `in_ready` low until the port drains.
- R9: With ready high, each forwarded write gives exactly one cycle of valid. Writes accepted on consecutive cycles give valid on consecutive cycles.
- R10: Each subchannel's binding is independent. Binding or failing to rebind one subchannel never changes another subchannel's route or `bound_mask` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input write present |
| in_ready | output | 1 | Input write accepted this cycle when high with in_valid |
| in_method | input | 13 | Method number |
| in_subch | input | 3 | Subchannel index |
| in_value | input | 32 | Write value, or class number for a bind |
| o2d_valid | output | 1 | 2D port write valid |
| o2d_ready | input | 1 | 2D port ready |
| o2d_method | output | 13 | 2D port method |
| o2d_value | output | 32 | 2D port value |
| o3d_valid | output | 1 | 3D port write valid |
| o3d_ready | input | 1 | 3D port ready |
| o3d_method | output | 13 | 3D port method |
| o3d_value | output | 32 | 3D port value |
| ocmp_valid | output | 1 | Compute port write valid |
| ocmp_ready | input | 1 | Compute port ready |
| ocmp_method | output | 13 | Compute port method |
| ocmp_value | output | 32 | Compute port value |
| bound_mask | output | 8 | One bit per subchannel, high when bound |
| err_rebind | output | 8 | One-cycle pulse on the subchannel of a rejected rebind |
| err_unbound | output | 8 | One-cycle pulse on the subchannel of a write with no binding |
| err_unsup | output | 8 | One-cycle pulse on the subchannel of a write to a portless class |

## Verification
The bench binds all eight subchannels across every routed class, both portless recognised classes and one unknown class. It then sweeps engine writes over every subchannel. A router that indexed its table by the wrong field, or confused two class codes, would send data to the wrong port.

The bench also sweeps the whole reserved range 0x001 to 0x0FF, which catches an off-by-one limit that either leaks method 0x0FF or swallows 0x100. It attempts a rebind with a different class to expose a table that overwrites on a second bind.

Finally, it stalls the 3D port to catch a stage that drops or overwrites held data, and sends back-to-back writes to catch a stage that inserts a bubble.

// File: rtl/subch_router_pkg.sv
package subch_router_pkg;

  typedef enum logic [1:0] {
    TGT_2D   = 2'd0,
    TGT_3D   = 2'd1,
    TGT_CMP  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  localparam int NUM_PORTS = 3;

  localparam logic [31:0] CLASS_2D     = 32'h0000_902D;
  localparam logic [31:0] CLASS_3D     = 32'h0000_B197;
  localparam logic [31:0] CLASS_CMP    = 32'h0000_B1C0;
  localparam logic [31:0] CLASS_INLMEM = 32'h0000_A140;
  localparam logic [31:0] CLASS_COPY   = 32'h0000_B0B5;

endpackage

// File: rtl/subch_class_decode.sv
module subch_class_decode
  import subch_router_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cls,
  output tgt_e              tgt
);

  // Recognised classes without a port fall into TGT_NONE with unknown ones.
  always_comb begin
    unique case (cls)
      DATA_W'(CLASS_2D):  tgt = TGT_2D;
      DATA_W'(CLASS_3D):  tgt = TGT_3D;
      DATA_W'(CLASS_CMP): tgt = TGT_CMP;
      default:            tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/subch_bind_table.sv
module subch_bind_table
  import subch_router_pkg::*;
#(
  parameter int NUM_SUBCH = 8,
  localparam int IDX_W = (NUM_SUBCH > 1) ? $clog2(NUM_SUBCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  tgt_e                 wr_tgt,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_bound,
  output tgt_e                 rd_tgt,
  output logic [NUM_SUBCH-1:0] bound_mask
);

  // Targets sit in an unreset array; only the valid bits carry reset.
  tgt_e                 tgt_mem [NUM_SUBCH];
  logic [NUM_SUBCH-1:0] bound_q;

  always_ff @(posedge clk) begin
    if (wr_en) tgt_mem[wr_idx] <= wr_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst)        bound_q <= '0;
    else if (wr_en) bound_q[wr_idx] <= 1'b1;
  end

  assign rd_bound   = bound_q[rd_idx];
  assign rd_tgt     = tgt_mem[rd_idx];
  assign bound_mask = bound_q;

endmodule

// File: rtl/subch_out_port.sv
module subch_out_port #(
  parameter int METHOD_W = 13,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [METHOD_W-1:0] ld_method,
  input  logic [DATA_W-1:0]   ld_value,
  output logic                can_load,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [METHOD_W-1:0] o_method,
  output logic [DATA_W-1:0]   o_value
);

  logic                valid_q;
  logic [METHOD_W-1:0] method_q;
  logic [DATA_W-1:0]   value_q;

  assign can_load = !valid_q || o_ready;

  always_ff @(posedge clk) begin
    if (rst)          valid_q <= 1'b0;
    else if (load)    valid_q <= 1'b1;
    else if (o_ready) valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      method_q <= ld_method;
      value_q  <= ld_value;
    end
  end

  assign o_valid  = valid_q;
  assign o_method = method_q;
  assign o_value  = value_q;

endmodule

// File: rtl/subch_router.sv
module subch_router
  import subch_router_pkg::*;
#(
  parameter int NUM_SUBCH  = 8,
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32,
  parameter int RSVD_LIMIT = 256,
  localparam int SUBCH_W = (NUM_SUBCH > 1) ? $clog2(NUM_SUBCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [METHOD_W-1:0]  in_method,
  input  logic [SUBCH_W-1:0]   in_subch,
  input  logic [DATA_W-1:0]    in_value,
  output logic                 o2d_valid,
  input  logic                 o2d_ready,
  output logic [METHOD_W-1:0]  o2d_method,
  output logic [DATA_W-1:0]    o2d_value,
  output logic                 o3d_valid,
  input  logic                 o3d_ready,
  output logic [METHOD_W-1:0]  o3d_method,
  output logic [DATA_W-1:0]    o3d_value,
  output logic                 ocmp_valid,
  input  logic                 ocmp_ready,
  output logic [METHOD_W-1:0]  ocmp_method,
  output logic [DATA_W-1:0]    ocmp_value,
  output logic [NUM_SUBCH-1:0] bound_mask,
  output logic [NUM_SUBCH-1:0] err_rebind,
  output logic [NUM_SUBCH-1:0] err_unbound,
  output logic [NUM_SUBCH-1:0] err_unsup
);

  localparam logic [NUM_SUBCH-1:0] ONE_HOT0 = NUM_SUBCH'(1);

  // Classify the write by method range.
  logic is_bind, is_rsvd, is_eng;
  assign is_bind = (in_method == '0);
  assign is_rsvd = !is_bind && (in_method < METHOD_W'(RSVD_LIMIT));
  assign is_eng  = !is_bind && !is_rsvd;

  // Table lookup for the write's subchannel.
  logic rd_bound;
  tgt_e rd_tgt;
  tgt_e new_tgt;
  logic tbl_wr;

  subch_class_decode #(.DATA_W(DATA_W)) dec_i (
    .cls (in_value),
    .tgt (new_tgt)
  );

  subch_bind_table #(.NUM_SUBCH(NUM_SUBCH)) tbl_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (tbl_wr),
    .wr_idx     (in_subch),
    .wr_tgt     (new_tgt),
    .rd_idx     (in_subch),
    .rd_bound   (rd_bound),
    .rd_tgt     (rd_tgt),
    .bound_mask (bound_mask)
  );

  // Port stages, packed into arrays.
  logic                port_ready  [NUM_PORTS];
  logic                port_valid  [NUM_PORTS];
  logic [METHOD_W-1:0] port_method [NUM_PORTS];
  logic [DATA_W-1:0]   port_value  [NUM_PORTS];
  logic                port_load   [NUM_PORTS];
  logic                port_can    [NUM_PORTS];

  assign port_ready[0] = o2d_ready;
  assign port_ready[1] = o3d_ready;
  assign port_ready[2] = ocmp_ready;

  logic fwd, sel_can, fire;
  assign fwd = is_eng && rd_bound && (rd_tgt != TGT_NONE);

  always_comb begin
    unique case (rd_tgt)
      TGT_2D:  sel_can = port_can[0];
      TGT_3D:  sel_can = port_can[1];
      TGT_CMP: sel_can = port_can[2];
      default: sel_can = 1'b1;
    endcase
  end

  assign in_ready = !fwd || sel_can;
  assign fire     = in_valid && in_ready;
  assign tbl_wr   = fire && is_bind && !rd_bound;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_load[p] = fire && fwd && (rd_tgt == tgt_e'(2'(p)));

    subch_out_port #(.METHOD_W(METHOD_W), .DATA_W(DATA_W)) port_i (
      .clk       (clk),
      .rst       (rst),
      .load      (port_load[p]),
      .ld_method (in_method),
      .ld_value  (in_value),
      .can_load  (port_can[p]),
      .o_valid   (port_valid[p]),
      .o_ready   (port_ready[p]),
      .o_method  (port_method[p]),
      .o_value   (port_value[p])
    );
  end

  assign o2d_valid   = port_valid[0];
  assign o2d_method  = port_method[0];
  assign o2d_value   = port_value[0];
  assign o3d_valid   = port_valid[1];
  assign o3d_method  = port_method[1];
  assign o3d_value   = port_value[1];
  assign ocmp_valid  = port_valid[2];
  assign ocmp_method = port_method[2];
  assign ocmp_value  = port_value[2];

  // Registered one-hot error pulses.
  logic [NUM_SUBCH-1:0] sub_oh;
  logic [NUM_SUBCH-1:0] rebind_q, unbound_q, unsup_q;
  assign sub_oh = ONE_HOT0 << in_subch;

  always_ff @(posedge clk) begin
    if (rst) begin
      rebind_q  <= '0;
      unbound_q <= '0;
      unsup_q   <= '0;
    end else begin
      rebind_q  <= (fire && is_bind && rd_bound) ? sub_oh : '0;
      unbound_q <= (fire && is_eng && !rd_bound) ? sub_oh : '0;
      unsup_q   <= (fire && is_eng && rd_bound && rd_tgt == TGT_NONE) ? sub_oh : '0;
    end
  end

  assign err_rebind  = rebind_q;
  assign err_unbound = unbound_q;
  assign err_unsup   = unsup_q;

endmodule

// File: rtl/subch_router_chk.sv
module subch_router_chk #(
  parameter int NUM_SUBCH  = 8,
  parameter int METHOD_W   = 13,
  parameter int DATA_W     = 32,
  parameter int RSVD_LIMIT = 256,
  localparam int SUBCH_W = (NUM_SUBCH > 1) ? $clog2(NUM_SUBCH) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [METHOD_W-1:0]  in_method,
  input logic [SUBCH_W-1:0]   in_subch,
  input logic [DATA_W-1:0]    in_value,
  input logic                 o2d_valid,
  input logic                 o2d_ready,
  input logic [METHOD_W-1:0]  o2d_method,
  input logic [DATA_W-1:0]    o2d_value,
  input logic                 o3d_valid,
  input logic                 o3d_ready,
  input logic [METHOD_W-1:0]  o3d_method,
  input logic [DATA_W-1:0]    o3d_value,
  input logic                 ocmp_valid,
  input logic                 ocmp_ready,
  input logic [METHOD_W-1:0]  ocmp_method,
  input logic [DATA_W-1:0]    ocmp_value,
  input logic [NUM_SUBCH-1:0] bound_mask,
  input logic [NUM_SUBCH-1:0] err_rebind,
  input logic [NUM_SUBCH-1:0] err_unbound,
  input logic [NUM_SUBCH-1:0] err_unsup
);

  logic fire;
  assign fire = in_valid && in_ready;

  p_bind_sets_mask_r1: assert property (@(posedge clk) disable iff (rst)
    fire && in_method == '0 |=> bound_mask[$past(in_subch)]);

  p_rsvd_silent_r2: assert property (@(posedge clk) disable iff (rst)
    fire && in_method != '0 && in_method < METHOD_W'(RSVD_LIMIT)
    |=> (err_rebind | err_unbound | err_unsup) == '0);

  p_rebind_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_rebind));

  p_unbound_flag_r6: assert property (@(posedge clk) disable iff (rst)
    fire && in_method >= METHOD_W'(RSVD_LIMIT) && !bound_mask[in_subch]
    |=> err_unbound[$past(in_subch)]);

  p_mask_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~bound_mask & $past(bound_mask)) == '0));

  p_hold_2d_r8: assert property (@(posedge clk) disable iff (rst)
    o2d_valid && !o2d_ready |=> o2d_valid && $stable(o2d_method) && $stable(o2d_value));

  p_hold_3d_r8: assert property (@(posedge clk) disable iff (rst)
    o3d_valid && !o3d_ready |=> o3d_valid && $stable(o3d_method) && $stable(o3d_value));

  p_hold_cmp_r8: assert property (@(posedge clk) disable iff (rst)
    ocmp_valid && !ocmp_ready |=> ocmp_valid && $stable(ocmp_method) && $stable(ocmp_value));

endmodule

bind subch_router subch_router_chk #(
  .NUM_SUBCH(NUM_SUBCH), .METHOD_W(METHOD_W), .DATA_W(DATA_W), .RSVD_LIMIT(RSVD_LIMIT)
) chk_i (.*);

// File: tb/subch_router_tb_top.sv
module subch_router_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_method = '0;
  logic [2:0]  in_subch = '0;
  logic [31:0] in_value = '0;
  logic        v2d, v3d, vcmp;
  logic        r2d = 1'b1, r3d = 1'b1, rcmp = 1'b1;
  logic [12:0] m2d, m3d, mcmp;
  logic [31:0] d2d, d3d, dcmp;
  logic [7:0]  bmask, e_rb, e_ub, e_us;

  subch_router dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_method(in_method), .in_subch(in_subch), .in_value(in_value),
    .o2d_valid(v2d), .o2d_ready(r2d), .o2d_method(m2d), .o2d_value(d2d),
    .o3d_valid(v3d), .o3d_ready(r3d), .o3d_method(m3d), .o3d_value(d3d),
    .ocmp_valid(vcmp), .ocmp_ready(rcmp), .ocmp_method(mcmp), .ocmp_value(dcmp),
    .bound_mask(bmask), .err_rebind(e_rb), .err_unbound(e_ub), .err_unsup(e_us)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          mb [8];
  logic [31:0] mc [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port index from class: 0=2D 1=3D 2=compute, -1 none.
  function automatic int port_of(input logic [31:0] c);
    if (c == 32'h902D) return 0;
    if (c == 32'hB197) return 1;
    if (c == 32'hB1C0) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] model_mask();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = mb[i];
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin mb[i] = 0; mc[i] = '0; end
  endtask

  task automatic issue(input logic [12:0] m, input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_method = m; in_subch = s; in_value = v;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_write(input logic [12:0] m, input logic [2:0] s,
                          input logic [31:0] v, input string req);
    int ep;
    logic [7:0] xrb, xub, xus, oh;
    logic [2:0] pv, xpv;
    ep = -1; xrb = '0; xub = '0; xus = '0;
    oh = 8'd1 << s;
    if (m == 13'd0) begin
      if (mb[s]) xrb = oh;
      else begin mb[s] = 1; mc[s] = v; end
    end else if (m >= 13'h100) begin
      if (!mb[s]) xub = oh;
      else if (port_of(mc[s]) < 0) xus = oh;
      else ep = port_of(mc[s]);
    end
    issue(m, s, v);
    @(negedge clk);
    pv  = {vcmp, v3d, v2d};
    xpv = (ep >= 0) ? (3'd1 << ep) : 3'd0;
    chk(pv == xpv, req, 64'(pv), 64'(xpv));
    if (ep == 0) chk(m2d == m && d2d == v, req, {19'd0, m2d, d2d}, {19'd0, m, v});
    if (ep == 1) chk(m3d == m && d3d == v, req, {19'd0, m3d, d3d}, {19'd0, m, v});
    if (ep == 2) chk(mcmp == m && dcmp == v, req, {19'd0, mcmp, dcmp}, {19'd0, m, v});
    chk({e_rb, e_ub, e_us} == {xrb, xub, xus}, req,
        64'({e_rb, e_ub, e_us}), 64'({xrb, xub, xus}));
    chk(bmask == model_mask(), req, 64'(bmask), 64'(model_mask()));
    @(negedge clk);
    pv = {vcmp, v3d, v2d};
    chk(pv == 3'd0 && {e_rb, e_ub, e_us} == '0, "R9 pulse width",
        64'({pv, e_rb, e_ub, e_us}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] classes [6];
    classes[0] = 32'h902D; classes[1] = 32'hB197; classes[2] = 32'hB1C0;
    classes[3] = 32'hA140; classes[4] = 32'hB0B5; classes[5] = 32'h1234;

    do_reset();
    @(negedge clk);
    // R7: reset state
    chk(bmask == 8'd0, "R7 mask after reset", 64'(bmask), 0);
    chk({v2d, v3d, vcmp} == 3'd0, "R7 valids after reset", 64'({v2d, v3d, vcmp}), 0);
    chk({e_rb, e_ub, e_us} == '0, "R7 flags after reset", 64'({e_rb, e_ub, e_us}), 0);

    // R6: engine write on an unbound subchannel
    do_write(13'h200, 3'd7, 32'hDEAD_0007, "R6 unbound write");

    // R1 / R10: bind every subchannel, one at a time
    for (int s = 0; s < 8; s++)
      do_write(13'h0, 3'(s), classes[s % 6], "R1 bind");

    // R5: rebind with another class leaves the route unchanged
    do_write(13'h0, 3'd0, 32'hB197, "R5 rebind rejected");
    do_write(13'h300, 3'd0, 32'h0000_5A5A, "R5 route kept after rebind");
    do_write(13'h0, 3'd3, 32'h902D, "R5 rebind on portless class");

    // R3 / R4 / R10: sweep engine writes over all subchannels
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        do_write(13'h100 + 13'(s * 13'h111) + 13'(k * 3), 3'(s),
                 (32'h0101_0101 * s) ^ 32'(k),
                 (port_of(classes[s % 6]) < 0) ? "R4 portless class" : "R3 route");
    do_write(13'h1FFF, 3'd2, 32'hFFFF_FFFF, "R3 top method");

    // R2: whole reserved range on a routed subchannel
    for (int m = 1; m < 256; m++)
      do_write(13'(m), 3'd1, 32'(m), "R2 reserved method");
    do_write(13'h100, 3'd1, 32'h0000_0100, "R2 first engine method");

    // R8: backpressure on the 3D port
    @(negedge clk);
    r3d = 1'b0;
    issue(13'h1A0, 3'd1, 32'hAAAA_0001);
    @(negedge clk);
    chk(v3d && m3d == 13'h1A0, "R8 first write held", 64'({v3d, m3d}), 64'({1'b1, 13'h1A0}));
    in_valid = 1'b1; in_method = 13'h1B0; in_subch = 3'd1; in_value = 32'hBBBB_0002;
    #1;
    chk(!in_ready, "R8 input stalled", 64'(in_ready), 0);
    @(negedge clk);
    chk(v3d && m3d == 13'h1A0 && d3d == 32'hAAAA_0001, "R8 data stable",
        64'({v3d, m3d, d3d}), 64'({1'b1, 13'h1A0, 32'hAAAA_0001}));
    r3d = 1'b1;
    #1;
    chk(in_ready, "R8 stall released", 64'(in_ready), 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(v3d && m3d == 13'h1B0 && d3d == 32'hBBBB_0002, "R8 second write delivered",
        64'({v3d, m3d, d3d}), 64'({1'b1, 13'h1B0, 32'hBBBB_0002}));
    @(negedge clk);
    chk(!v3d, "R8 drained", 64'(v3d), 0);

    // R9: back-to-back writes on the 2D port (subchannels 0 and 6)
    @(negedge clk);
    in_valid = 1'b1; in_method = 13'h120; in_subch = 3'd0; in_value = 32'd1;
    @(negedge clk);
    chk(v2d && m2d == 13'h120, "R9 first of pair", 64'({v2d, m2d}), 64'({1'b1, 13'h120}));
    in_method = 13'h130; in_subch = 3'd6; in_value = 32'd2;
    @(negedge clk);
    chk(v2d && m2d == 13'h130 && d2d == 32'd2, "R9 second of pair",
        64'({v2d, m2d}), 64'({1'b1, 13'h130}));
    in_valid = 1'b0;
    @(negedge clk);
    chk(!v2d, "R9 no extra valid", 64'(v2d), 0);

    // R7: reset clears bindings
    do_reset();
    @(negedge clk);
    chk(bmask == 8'd0, "R7 mask after second reset", 64'(bmask), 0);
    do_write(13'h140, 3'd0, 32'h1, "R7 binding gone after reset");
    do_write(13'h0, 3'd4, 32'hB1C0, "R7 fresh bind after reset");
    do_write(13'h150, 3'd4, 32'h77, "R7 route after fresh bind");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule